// File: doc/BRIEF.md
# Atomic Address Lock Table

This block lives inside a private cache controller and remembers which cache-line addresses are pinned while an atomic read-modify-write sequence is in flight. The protocol engine issues a lock pulse for each line it pins and a release pulse naming a line once that line's part of the sequence is finished. A clear pulse drops every pin at once. Incoming coherence traffic (forwarded, network and on-chip requests) presents its line address on a compare port. The block answers in the same cycle whether the request has to be held back.

The table holds a fixed number of slots, four by default. A lock writes the slot whose number equals the new outstanding count: the first lock goes to slot 1, the second to slot 2, and so on. A release frees the lowest-numbered held slot with a matching address. The block also watches the core-side request stream. When an ordinary, non-atomic core request arrives while anything is pinned, every pin is dropped. Misuse of the lock or release commands raises a sticky error flag and leaves the table untouched.

Top module: `atomic_lock_table`

## Requirements
- R1: After reset the count is 0, `held_mask` is 0, `err` is 0 and `ext_defer` is 0 for any address.
- R2: An accepted lock stores its address in slot number count+1 and increments the count. Slot number k is reported on `held_mask` bit k-1.
- R3: A lock issued when the count equals the slot total, or when slot count+1 is already held, sets `err` and leaves the count and every slot unchanged.
- R4: An accepted release clears only the lowest-numbered held slot whose address equals `rel_addr`, and decrements the count. Any other held slot with the same address stays held.
- R5: A release issued when the count is 0, or one whose address matches no held slot, sets `err` and leaves the table unchanged.
- R6: A `clr_all` pulse empties every slot, zeroes the count and clears `err`. It overrides a lock, a release or a core flush in the same cycle.
- R7: `ext_defer` is high in the same cycle exactly when `ext_vld` is high and `ext_addr` equals the address of some held slot, the last slot included.
- R8: A core request (`core_req_vld`) with `core_req_atomic` low, arriving while the count is non-zero, empties every slot and zeroes the count. `err` keeps its value. This flush overrides a lock or release in the same cycle. A core request with `core_req_atomic` high, or any core request while the count is 0, has no effect.
- R9: Lock and release pulsed in the same cycle (with no clear or flush) set `err` and change nothing in the table.
- R10: The count always equals the number of held slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_vld | input | 1 | Lock command pulse |
| lock_addr | input | ADDR_W | Line address to lock |
| rel_vld | input | 1 | Release command pulse |
| rel_addr | input | ADDR_W | Line address to release |
| clr_all | input | 1 | Release-everything pulse |
| core_req_vld | input | 1 | Core-side request seen this cycle |
| core_req_atomic | input | 1 | Core request is part of an atomic |
| ext_vld | input | 1 | External coherence request present |
| ext_addr | input | ADDR_W | External request line address |
| ext_defer | output | 1 | External request must be held back |
| held_mask | output | SLOTS | Per-slot held flag, bit k-1 for slot k |
| lock_count | output | CNT_W | Outstanding lock count |
| err | output | 1 | Sticky command-misuse flag |

## Verification
The hardest state to reach is a lock that targets an occupied slot while the table is not full. A sequence that only locks and then clears never gets there. The bench locks three lines, releases the middle one so that the count drops to two while slot 3 is still held, and then issues a fourth lock that has to collide with slot 3. A second sequence locks the same line twice, so a release has two matching slots to choose from. This shows that only the lower slot is freed and that the deferral for that line still holds.

// File: rtl/atomic_lock_pkg.sv
// Package: shared types for the atomic lock table.
// Assumes: nothing beyond the standard language.
package atomic_lock_pkg;

    // Outcome the controller decides for the current cycle.
    typedef enum logic [2:0] {
        OP_IDLE    = 3'd0,
        OP_LOCK    = 3'd1,
        OP_RELEASE = 3'd2,
        OP_WIPE    = 3'd3,
        OP_FAULT   = 3'd4
    } lock_op_e;

endpackage

// File: rtl/atomic_lock_slot.sv
// Module: one lock slot. Holds a valid flag and a line address, and
// compares that address with the release address and with the external
// request address.
// Assumes: load, drop and wipe come from the controller and load/drop
// are never both high in a cycle; wipe has priority.
module atomic_lock_slot #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              drop,
    input  logic              wipe,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [ADDR_W-1:0] rel_addr,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic              held,
    output logic              rel_hit,
    output logic              ext_hit
);

    logic [ADDR_W-1:0] line_q;
    logic              held_q;

    // Purpose: update the valid flag on wipe, load or drop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
        end else if (wipe) begin
            held_q <= 1'b0;
        end else if (load) begin
            held_q <= 1'b1;
        end else if (drop) begin
            held_q <= 1'b0;
        end
    end

    // Purpose: capture the line address when the slot is filled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
        end else if (load && !wipe) begin
            line_q <= load_addr;
        end
    end

    // Purpose: address comparisons, qualified by the valid flag.
    always_comb begin
        held    = held_q;
        rel_hit = held_q && (line_q == rel_addr);
        ext_hit = held_q && (line_q == ext_addr);
    end

endmodule

// File: rtl/atomic_lock_ctrl.sv
// Module: controller for the lock table. Decides each cycle whether to
// wipe, lock, release or flag a fault. Keeps the outstanding count and
// the sticky error flag, and produces one-hot load/drop selects.
// Assumes: held and rel_hit are registered slot outputs from this cycle.
module atomic_lock_ctrl
    import atomic_lock_pkg::*;
#(
    parameter int SLOTS = 4,
    parameter int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_vld,
    input  logic             rel_vld,
    input  logic             clr_all,
    input  logic             core_req_vld,
    input  logic             core_req_atomic,
    input  logic [SLOTS-1:0] held,
    input  logic [SLOTS-1:0] rel_hit,
    output logic [SLOTS-1:0] load_sel,
    output logic [SLOTS-1:0] drop_sel,
    output logic             wipe,
    output logic [CNT_W-1:0] count,
    output logic             err
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(SLOTS);

    logic [CNT_W-1:0] count_q;
    logic             err_q;
    logic             flush;
    logic             target_free;
    logic             lock_ok;
    logic             rel_ok;
    logic [SLOTS-1:0] first_hit;
    lock_op_e         op;

    // Purpose: detect a non-atomic core request that drops all pins.
    always_comb begin
        flush = core_req_vld && !core_req_atomic && (count_q != '0);
        wipe  = clr_all || flush;
    end

    // Purpose: check whether the slot the next lock targets is empty.
    always_comb begin
        target_free = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            if (count_q == CNT_W'(i)) begin
                target_free = !held[i];
            end
        end
    end

    // Purpose: pick the lowest-numbered matching slot for a release.
    always_comb begin
        logic found;
        found     = 1'b0;
        first_hit = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (rel_hit[i] && !found) begin
                first_hit[i] = 1'b1;
                found        = 1'b1;
            end
        end
    end

    // Purpose: decide whether each command is legal this cycle.
    always_comb begin
        lock_ok = lock_vld && !rel_vld && (count_q < FULL) && target_free;
        rel_ok  = rel_vld && !lock_vld && (count_q != '0) && (|rel_hit);
    end

    // Purpose: settle the single operation for this cycle, by priority.
    always_comb begin
        if (wipe) begin
            op = OP_WIPE;
        end else if (lock_ok) begin
            op = OP_LOCK;
        end else if (rel_ok) begin
            op = OP_RELEASE;
        end else if (lock_vld || rel_vld) begin
            op = OP_FAULT;
        end else begin
            op = OP_IDLE;
        end
    end

    // Purpose: steer the slot selects from the chosen operation.
    always_comb begin
        load_sel = '0;
        drop_sel = '0;
        for (int i = 0; i < SLOTS; i++) begin
            load_sel[i] = (op == OP_LOCK) && (count_q == CNT_W'(i));
        end
        if (op == OP_RELEASE) begin
            drop_sel = first_hit;
        end
    end

    // Purpose: keep the outstanding count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            case (op)
                OP_WIPE:    count_q <= '0;
                OP_LOCK:    count_q <= count_q + 1'b1;
                OP_RELEASE: count_q <= count_q - 1'b1;
                default:    count_q <= count_q;
            endcase
        end
    end

    // Purpose: sticky error, cleared only by reset or the clear command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (clr_all) begin
            err_q <= 1'b0;
        end else if (op == OP_FAULT) begin
            err_q <= 1'b1;
        end
    end

    assign count = count_q;
    assign err   = err_q;

endmodule

// File: rtl/atomic_lock_table.sv
// Module: top of the atomic lock table. Instantiates one slot per lock
// and the controller, and forms the combinational deferral answer.
// Assumes: lock, release and clear are single-cycle pulses; ext_addr is
// stable while ext_vld is high within a cycle.
module atomic_lock_table #(
    parameter int ADDR_W = 32,
    parameter int SLOTS  = 4,
    parameter int CNT_W  = $clog2(SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_vld,
    input  logic [ADDR_W-1:0] lock_addr,
    input  logic              rel_vld,
    input  logic [ADDR_W-1:0] rel_addr,
    input  logic              clr_all,
    input  logic              core_req_vld,
    input  logic              core_req_atomic,
    input  logic              ext_vld,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic              ext_defer,
    output logic [SLOTS-1:0]  held_mask,
    output logic [CNT_W-1:0]  lock_count,
    output logic              err
);

    logic [SLOTS-1:0] held;
    logic [SLOTS-1:0] rel_hit;
    logic [SLOTS-1:0] ext_hit;
    logic [SLOTS-1:0] load_sel;
    logic [SLOTS-1:0] drop_sel;
    logic             wipe;

    // One slot per lock entry.
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        atomic_lock_slot #(
            .ADDR_W (ADDR_W)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (load_sel[g]),
            .drop      (drop_sel[g]),
            .wipe      (wipe),
            .load_addr (lock_addr),
            .rel_addr  (rel_addr),
            .ext_addr  (ext_addr),
            .held      (held[g]),
            .rel_hit   (rel_hit[g]),
            .ext_hit   (ext_hit[g])
        );
    end

    atomic_lock_ctrl #(
        .SLOTS (SLOTS),
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .lock_vld        (lock_vld),
        .rel_vld         (rel_vld),
        .clr_all         (clr_all),
        .core_req_vld    (core_req_vld),
        .core_req_atomic (core_req_atomic),
        .held            (held),
        .rel_hit         (rel_hit),
        .load_sel        (load_sel),
        .drop_sel        (drop_sel),
        .wipe            (wipe),
        .count           (lock_count),
        .err             (err)
    );

    // Purpose: hold back an external request that hits any held slot.
    always_comb begin
        ext_defer = ext_vld && (|ext_hit);
        held_mask = held;
    end

endmodule

// File: rtl/atomic_lock_table_chk.sv
// Module: assertion checker for the atomic lock table, bound to the top.
// Assumes: observes only the top-level ports.
module atomic_lock_table_chk #(
    parameter int ADDR_W = 32,
    parameter int SLOTS  = 4,
    parameter int CNT_W  = $clog2(SLOTS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lock_vld,
    input logic              rel_vld,
    input logic              clr_all,
    input logic              core_req_vld,
    input logic              core_req_atomic,
    input logic              ext_vld,
    input logic              ext_defer,
    input logic [SLOTS-1:0]  held_mask,
    input logic [CNT_W-1:0]  lock_count,
    input logic              err
);

    logic flush_now;
    logic quiet;
    logic slot_free;

    always_comb begin
        flush_now = core_req_vld && !core_req_atomic && (lock_count != '0);
        quiet     = !clr_all && !flush_now;
        slot_free = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            if (lock_count == CNT_W'(i)) begin
                slot_free = !held_mask[i];
            end
        end
    end

    assert_count_tracks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(held_mask) == int'(lock_count));

    assert_lock_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_vld && !rel_vld && quiet && slot_free && (lock_count < CNT_W'(SLOTS)))
        |=> (lock_count == $past(lock_count) + 1'b1));

    assert_full_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_vld && !rel_vld && quiet && (lock_count == CNT_W'(SLOTS)))
        |=> (err && $stable(held_mask)));

    assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clr_all) |=> err);

    assert_empty_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_vld && quiet && (lock_count == '0)) |=> (err && (held_mask == '0)));

    assert_clear_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> ((lock_count == '0) && (held_mask == '0) && !err));

    assert_core_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_now |=> ((lock_count == '0) && (held_mask == '0)));

    assert_defer_needs_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ext_defer |-> (ext_vld && (held_mask != '0)));

    assert_both_cmds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_vld && rel_vld && quiet) |=> (err && $stable(lock_count)));

endmodule

bind atomic_lock_table atomic_lock_table_chk #(
    .ADDR_W (ADDR_W),
    .SLOTS  (SLOTS),
    .CNT_W  (CNT_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .lock_vld        (lock_vld),
    .rel_vld         (rel_vld),
    .clr_all         (clr_all),
    .core_req_vld    (core_req_vld),
    .core_req_atomic (core_req_atomic),
    .ext_vld         (ext_vld),
    .ext_defer       (ext_defer),
    .held_mask       (held_mask),
    .lock_count      (lock_count),
    .err             (err)
);

// File: tb/sim_atomic_lock_table.sv
// Directed bench for the atomic lock table: one task per scenario.
module sim_atomic_lock_table;

    localparam int AW = 32;
    localparam int NS = 4;
    localparam int CW = $clog2(NS + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lock_vld = 1'b0;
    logic [AW-1:0] lock_addr = '0;
    logic          rel_vld = 1'b0;
    logic [AW-1:0] rel_addr = '0;
    logic          clr_all = 1'b0;
    logic          core_req_vld = 1'b0;
    logic          core_req_atomic = 1'b0;
    logic          ext_vld = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic          ext_defer;
    logic [NS-1:0] held_mask;
    logic [CW-1:0] lock_count;
    logic          err;

    int checks = 0;
    int fails  = 0;

    localparam logic [AW-1:0] LA = 32'h0000_1000;
    localparam logic [AW-1:0] LB = 32'h0000_2040;
    localparam logic [AW-1:0] LC = 32'h0000_30C0;
    localparam logic [AW-1:0] LD = 32'hFFFF_FFC0;
    localparam logic [AW-1:0] LE = 32'h0000_5000;
    localparam logic [AW-1:0] LX = 32'h0BAD_0000;

    always #10 clk = ~clk;

    atomic_lock_table #(.ADDR_W(AW), .SLOTS(NS)) u0 (
        .clk(clk), .rst_n(rst_n),
        .lock_vld(lock_vld), .lock_addr(lock_addr),
        .rel_vld(rel_vld), .rel_addr(rel_addr),
        .clr_all(clr_all),
        .core_req_vld(core_req_vld), .core_req_atomic(core_req_atomic),
        .ext_vld(ext_vld), .ext_addr(ext_addr),
        .ext_defer(ext_defer), .held_mask(held_mask),
        .lock_count(lock_count), .err(err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic state(input string req, input int cnt, input logic [NS-1:0] msk, input logic e);
        chk({req, " count"}, 32'(lock_count), 32'(cnt));
        chk({req, " mask"}, 32'(held_mask), 32'(msk));
        chk({req, " err"}, 32'(err), 32'(e));
    endtask

    task automatic probe(input string req, input logic [AW-1:0] a, input logic exp);
        ext_vld  = 1'b1;
        ext_addr = a;
        #1;
        chk(req, 32'(ext_defer), 32'(exp));
        ext_vld = 1'b0;
    endtask

    // One command cycle: drive at a falling edge, return at the next one.
    task automatic cmd(input logic lk, input logic [AW-1:0] la, input logic rl,
                       input logic [AW-1:0] ra, input logic cl,
                       input logic cv, input logic ca);
        @(negedge clk);
        lock_vld = lk; lock_addr = la; rel_vld = rl; rel_addr = ra;
        clr_all = cl; core_req_vld = cv; core_req_atomic = ca;
        @(negedge clk);
        lock_vld = 0; rel_vld = 0; clr_all = 0; core_req_vld = 0; core_req_atomic = 0;
    endtask

    task automatic lk(input logic [AW-1:0] a);  cmd(1, a, 0, '0, 0, 0, 0); endtask
    task automatic rl(input logic [AW-1:0] a);  cmd(0, '0, 1, a, 0, 0, 0); endtask
    task automatic wipe_all();                  cmd(0, '0, 0, '0, 1, 0, 0); endtask

    task automatic t_reset();
        state("R1 reset", 0, 4'b0000, 0);
        probe("R1 no defer after reset", LA, 0);
    endtask

    task automatic t_fill_and_full();
        lk(LA); state("R2 first lock", 1, 4'b0001, 0);
        lk(LB); lk(LC); lk(LD);
        state("R2 four locks", 4, 4'b1111, 0);
        probe("R7 defer slot1", LA, 1);
        probe("R7 defer slot4", LD, 1);
        probe("R7 unlocked line", LE, 0);
        ext_vld = 0; ext_addr = LA; #1;
        chk("R7 no defer without ext_vld", 32'(ext_defer), 0);
        lk(LE); state("R3 lock when full", 4, 4'b1111, 1);
        probe("R3 rejected line not deferred", LE, 0);
        wipe_all(); state("R6 clear all", 0, 4'b0000, 0);
        probe("R6 no defer after clear", LB, 0);
    endtask

    task automatic t_release_gap();
        lk(LA); lk(LB); lk(LC);
        rl(LB); state("R4 release middle", 2, 4'b0101, 0);
        probe("R4 released line free", LB, 0);
        probe("R4 other line held", LC, 1);
        lk(LD); state("R3 target slot occupied", 2, 4'b0101, 1);
        wipe_all();
    endtask

    task automatic t_release_errors();
        rl(LA); state("R5 release at zero", 0, 4'b0000, 1);
        wipe_all();
        lk(LA); rl(LX); state("R5 release no match", 1, 4'b0001, 1);
        wipe_all();
    endtask

    task automatic t_duplicate();
        lk(LA); lk(LA);
        rl(LA); state("R4 duplicate lowest freed", 1, 4'b0010, 0);
        probe("R4 duplicate still deferred", LA, 1);
        rl(LA); state("R4 second duplicate freed", 0, 4'b0000, 0);
    endtask

    task automatic t_core_flush();
        lk(LA); lk(LB);
        cmd(0, '0, 0, '0, 0, 1, 1); state("R8 atomic core request ignored", 2, 4'b0011, 0);
        cmd(0, '0, 0, '0, 0, 1, 0); state("R8 flush", 0, 4'b0000, 0);
        probe("R8 no defer after flush", LA, 0);
        rl(LX);
        cmd(0, '0, 0, '0, 0, 1, 0); state("R8 flush at zero keeps err", 0, 4'b0000, 1);
        wipe_all();
        lk(LA);
        cmd(1, LB, 0, '0, 0, 1, 0); state("R8 flush beats lock", 0, 4'b0000, 0);
    endtask

    task automatic t_priority();
        lk(LA);
        cmd(1, LB, 0, '0, 1, 0, 0); state("R6 clear beats lock", 0, 4'b0000, 0);
        lk(LA);
        cmd(1, LB, 1, LA, 0, 0, 0); state("R9 lock and release together", 1, 4'b0001, 1);
        probe("R9 table kept", LA, 1);
        wipe_all();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill_and_full();
        t_release_gap();
        t_release_errors();
        t_duplicate();
        t_core_flush();
        t_priority();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule